// File: doc/BRIEF.md
# Power-Good Reset Sequencer

This block turns a power-good level and a clock/power-stable flag into a timed, active-low reset for a processor system bus. When power-good rises and the supplies and clocks are reported stable, it holds reset low for a set number of milliseconds. The millisecond base comes from a clock divider set by a parameter. It then releases reset and latches the strap inputs on the same edge. A second timer runs from the moment power-good is seen high. It caps the total time reset can stay low, so a flaky stable flag cannot hold the bus in reset indefinitely. An output-disable flag follows the reset within a fixed, parameterised number of clocks (one or two), so that bus drivers go inactive soon after reset is asserted.

Power-good low acts as the block's own reset. It sends the controller to its idle state, asserts reset at the next edge, and clears both the latched configuration and the violation flag. All inputs are taken to be synchronous to `clk`; analog filtering is outside the block.

The controller has four states. `ST_OFF`: power-good low. `ST_ARM`: power-good high, waiting for the stable flag. `ST_HOLD`: counting the reset width. `ST_RUN`: reset released. The transitions are:
- OFF to HOLD when power-good is high and stable is high.
- OFF to ARM when power-good is high and stable is low.
- ARM to HOLD when stable rises.
- HOLD to ARM when stable drops; this is a violation.
- HOLD to RUN when the width is reached.
- ARM or HOLD to RUN when the window cap expires; this is a forced release and a violation.
- Any state to OFF when power-good is low.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pwr_good` is sampled low, the next edge drives `rst_n_out` to 0 and `cfg_q` to all zeros, and clears `tim_viol` to 0.
- R2: If `pwr_good` is first sampled high at edge k with `clk_stable` high, `rst_n_out` stays 0 through edge k+N and becomes 1 at edge k+N+1, where N = RST_MS*CYC_PER_MS.
- R3: While `pwr_good` is high and `clk_stable` is low, reset is held. The full hold of N cycles is counted from the edge at which `clk_stable` is first sampled high, and `tim_viol` stays 0 for this case.
- R4: If `clk_stable` is sampled low during the hold, `tim_viol` becomes 1 at that edge and stays 1 until `pwr_good` falls. The hold restarts from zero once `clk_stable` returns.
- R5: Reset is never held low longer than MAX_MS milliseconds while `pwr_good` is high. If `pwr_good` is first sampled high at edge k and the hold has not completed, reset is forcibly released at edge k+MAX_MS*CYC_PER_MS+1, with `tim_viol` set to 1.
- R6: `out_dis` equals the inverse of `rst_n_out` delayed by OFF_DLY clocks (OFF_DLY is 1 or 2), so outputs are disabled at most two clocks after reset is asserted.
- R7: `cfg_q` takes the value of `straps` at the edge where `rst_n_out` goes from 0 to 1. After that it holds this value; later changes of `straps` while reset is released have no effect.
- R8: A fall of `pwr_good` while reset is released restarts the whole sequence: a new rising edge yields a new N-cycle pulse and a new strap capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Power-good level; low acts as reset |
| clk_stable | input | 1 | Supplies and clocks within specification |
| straps | input | STRAP_W | Configuration strap inputs |
| rst_n_out | output | 1 | Active-low bus reset |
| out_dis | output | 1 | Bus output disable, follows reset after OFF_DLY clocks |
| cfg_q | output | STRAP_W | Straps latched at reset release |
| tim_viol | output | 1 | Sticky flag: stable lost or window cap hit during reset |

## Verification
The bench builds the block with a 20-clock millisecond, a 2 ms nominal hold, a 5 ms cap, a two-stage disable delay and 4-bit straps. With these values a full pulse takes 41 cycles and the forced release takes 101. This makes the exact release edge, the cap-driven forced release, and a hold restarted after a stable drop reachable in a few hundred cycles. The two-stage disable delay exercises the longest permitted gap between reset and output blocking.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_HOLD = 2'd2,
        ST_RUN  = 2'd3
    } prs_state_e;

endpackage

// File: rtl/prs_ms_timer.sv
// Millisecond timer: a clock divider feeding a saturating ms counter.
module prs_ms_timer #(
    parameter int CYC_PER_MS = 1000,
    parameter int MS_MAX     = 10,
    localparam int DIV_W     = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1,
    localparam int MS_W      = $clog2(MS_MAX + 1)
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            en,
    output logic [MS_W-1:0] ms
);

    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_TOP   = MS_W'(MS_MAX);

    logic [DIV_W-1:0] div_q;
    logic [MS_W-1:0]  ms_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            div_q <= '0;
            ms_q  <= '0;
        end else if (en) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (ms_q != MS_TOP) begin
                    ms_q <= ms_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign ms = ms_q;

endmodule

// File: rtl/prs_out_gate.sv
// Output-disable delay line: out_dis follows reset assertion after DLY clocks.
module prs_out_gate #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n_in,
    output logic dis
);

    logic [DLY-1:0] pipe_q;

    always_ff @(posedge clk) begin
        pipe_q[0] <= ~rst_n_in;
    end

    for (genvar i = 1; i < DLY; i++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dis = pipe_q[DLY-1];

endmodule

// File: rtl/prs_strap_latch.sv
// Configuration latch: captured on reset release, cleared on power loss.
module prs_strap_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (clr) begin
            q_r <= '0;
        end else if (cap) begin
            q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import prs_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int RST_MS     = 2,
    parameter int MAX_MS     = 10,
    parameter int OFF_DLY    = 2,
    parameter int STRAP_W    = 8
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               clk_stable,
    input  logic [STRAP_W-1:0] straps,
    output logic               rst_n_out,
    output logic               out_dis,
    output logic [STRAP_W-1:0] cfg_q,
    output logic               tim_viol
);

    localparam int MS_W = $clog2(MAX_MS + 1);
    localparam logic [MS_W-1:0] HOLD_MS = MS_W'(RST_MS);
    localparam logic [MS_W-1:0] CAP_MS  = MS_W'(MAX_MS);

    prs_state_e state, state_nx;

    logic [MS_W-1:0] hold_ms;
    logic [MS_W-1:0] win_ms;
    logic            hold_done;
    logic            win_done;
    logic            set_viol;
    logic            rst_n_q;
    logic            viol_q;
    logic            cap_cfg;
    logic            clr_cfg;

    // Hold timer: runs only in ST_HOLD, restarts whenever it is left.
    prs_ms_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .MS_MAX     (MAX_MS)
    ) u_hold_tmr (
        .clk (clk),
        .clr (state != ST_HOLD),
        .en  (1'b1),
        .ms  (hold_ms)
    );

    // Window timer: runs while reset is held with power-good high.
    prs_ms_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .MS_MAX     (MAX_MS)
    ) u_win_tmr (
        .clk (clk),
        .clr ((state == ST_OFF) || (state == ST_RUN)),
        .en  (1'b1),
        .ms  (win_ms)
    );

    assign hold_done = (hold_ms == HOLD_MS);
    assign win_done  = (win_ms == CAP_MS);

    // State register.
    always_ff @(posedge clk) begin
        state <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        set_viol = 1'b0;
        if (!pwr_good) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_nx = clk_stable ? ST_HOLD : ST_ARM;
                end
                ST_ARM: begin
                    if (win_done) begin
                        state_nx = ST_RUN;
                        set_viol = 1'b1;
                    end else if (clk_stable) begin
                        state_nx = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (win_done) begin
                        state_nx = ST_RUN;
                        set_viol = 1'b1;
                    end else if (!clk_stable) begin
                        state_nx = ST_ARM;
                        set_viol = 1'b1;
                    end else if (hold_done) begin
                        state_nx = ST_RUN;
                    end
                end
                ST_RUN: begin
                    state_nx = ST_RUN;
                end
                default: begin
                    state_nx = ST_OFF;
                end
            endcase
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk) begin
        rst_n_q <= (state_nx == ST_RUN);
        if (state_nx == ST_OFF) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= viol_q | set_viol;
        end
    end

    assign cap_cfg = (state_nx == ST_RUN) && (state != ST_RUN);
    assign clr_cfg = (state_nx == ST_OFF);

    prs_strap_latch #(
        .W (STRAP_W)
    ) u_cfg (
        .clk (clk),
        .clr (clr_cfg),
        .cap (cap_cfg),
        .d   (straps),
        .q   (cfg_q)
    );

    prs_out_gate #(
        .DLY (OFF_DLY)
    ) u_gate (
        .clk      (clk),
        .rst_n_in (rst_n_q),
        .dis      (out_dis)
    );

    assign rst_n_out = rst_n_q;
    assign tim_viol  = viol_q;

endmodule

// File: rtl/prs_chk.sv
module prs_chk #(
    parameter int CYC_PER_MS = 100000,
    parameter int RST_MS     = 2,
    parameter int MAX_MS     = 10,
    parameter int STRAP_W    = 8,
    localparam int MIN_CYC   = RST_MS * CYC_PER_MS,
    localparam int MAX_CYC   = MAX_MS * CYC_PER_MS + 2,
    localparam int CNT_W     = $clog2(MAX_CYC + 4) + 1
) (
    input logic               clk,
    input logic               pwr_good,
    input logic               rst_n_out,
    input logic               out_dis,
    input logic [STRAP_W-1:0] cfg_q,
    input logic               tim_viol
);

    logic             init_q = 1'b0;
    logic [CNT_W-1:0] lo_cnt = '0;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            init_q <= 1'b1;
        end
        if (!pwr_good || rst_n_out) begin
            lo_cnt <= '0;
        end else if (lo_cnt != {CNT_W{1'b1}}) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    p_rst_on_pg_low_r1: assert property (@(posedge clk) disable iff (!init_q)
        !pwr_good |=> !rst_n_out);

    p_cfg_clear_r1: assert property (@(posedge clk) disable iff (!init_q)
        !pwr_good |=> (cfg_q == '0));

    p_viol_clear_r1: assert property (@(posedge clk) disable iff (!init_q)
        !pwr_good |=> !tim_viol);

    p_min_width_r2: assert property (@(posedge clk) disable iff (!init_q || !pwr_good)
        $rose(rst_n_out) |-> (lo_cnt >= CNT_W'(MIN_CYC)));

    p_max_width_r5: assert property (@(posedge clk) disable iff (!init_q || !pwr_good)
        lo_cnt <= CNT_W'(MAX_CYC));

    p_dis_follow_r6: assert property (@(posedge clk) disable iff (!init_q)
        (!rst_n_out ##1 !rst_n_out) |=> out_dis);

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!init_q)
        (rst_n_out && pwr_good) |=> (!rst_n_out || $stable(cfg_q)));

endmodule

bind pwr_rst_seq prs_chk #(
    .CYC_PER_MS (CYC_PER_MS),
    .RST_MS     (RST_MS),
    .MAX_MS     (MAX_MS),
    .STRAP_W    (STRAP_W)
) u_prs_chk (
    .clk       (clk),
    .pwr_good  (pwr_good),
    .rst_n_out (rst_n_out),
    .out_dis   (out_dis),
    .cfg_q     (cfg_q),
    .tim_viol  (tim_viol)
);

// File: tb/tb_pwr_rst_seq.sv
module tb_pwr_rst_seq;

    localparam int C   = 20;
    localparam int RMS = 2;
    localparam int XMS = 5;
    localparam int DLY = 2;
    localparam int SW  = 4;
    localparam int N   = RMS * C;

    localparam int S_RST  = 0;
    localparam int S_DIS  = 1;
    localparam int S_CFG  = 2;
    localparam int S_VIOL = 3;

    typedef struct {
        int          cyc;
        int          sig;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          pwr_good = 1'b0;
    logic          clk_stable = 1'b0;
    logic [SW-1:0] straps = '0;
    logic          rst_n_out;
    logic          out_dis;
    logic [SW-1:0] cfg_q;
    logic          tim_viol;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    pwr_rst_seq #(
        .CYC_PER_MS (C),
        .RST_MS     (RMS),
        .MAX_MS     (XMS),
        .OFF_DLY    (DLY),
        .STRAP_W    (SW)
    ) dut (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .clk_stable (clk_stable),
        .straps     (straps),
        .rst_n_out  (rst_n_out),
        .out_dis    (out_dis),
        .cfg_q      (cfg_q),
        .tim_viol   (tim_viol)
    );

    // 125 MHz: 8-unit period.
    always #4 clk = ~clk;

    // Monitor: count edges, pop and compare expected items that fall due.
    always begin
        @(posedge clk);
        cyc = cyc + 1;
        #3;
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t        it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.sig)
                S_RST:   act = {31'b0, rst_n_out};
                S_DIS:   act = {31'b0, out_dis};
                S_CFG:   act = 32'(cfg_q);
                default: act = {31'b0, tim_viol};
            endcase
            total = total + 1;
            if (act !== it.val) begin
                bad = bad + 1;
                $display("FAIL %s sig=%0d cycle=%0d actual=%0h expected=%0h",
                         it.tag, it.sig, cyc, act, it.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #4;
        end
    endtask

    // Driver side: push an expectation d edges from now.
    task automatic expect_at(input int d, input int sig, input logic [31:0] v, input string tag);
        exp_t it;
        it.cyc = cyc + d;
        it.sig = sig;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        tick(6);
        // R1: reset state with power-good low
        expect_at(1, S_RST, 0, "R1");
        expect_at(1, S_DIS, 1, "R1");
        expect_at(1, S_CFG, 0, "R1");
        expect_at(1, S_VIOL, 0, "R1");
        tick(2);

        // R2 / R6 / R7: clean power-up
        straps = 4'hA;
        clk_stable = 1'b1;
        pwr_good = 1'b1;
        expect_at(N + 1, S_RST, 0, "R2");
        expect_at(N + 2, S_RST, 1, "R2");
        expect_at(N + 2, S_CFG, 32'hA, "R7");
        expect_at(N + 3, S_DIS, 1, "R6");
        expect_at(N + 4, S_DIS, 0, "R6");
        tick(N + 6);
        straps = 4'h5;
        tick(3);
        expect_at(1, S_CFG, 32'hA, "R7");
        expect_at(1, S_RST, 1, "R7");
        tick(2);

        // R1 / R6 / R8: power-good loss and restart
        pwr_good = 1'b0;
        expect_at(1, S_RST, 0, "R1");
        expect_at(1, S_CFG, 0, "R1");
        expect_at(2, S_DIS, 0, "R6");
        expect_at(3, S_DIS, 1, "R6");
        tick(5);
        straps = 4'h3;
        pwr_good = 1'b1;
        expect_at(N + 1, S_RST, 0, "R8");
        expect_at(N + 2, S_RST, 1, "R8");
        expect_at(N + 2, S_CFG, 32'h3, "R8");
        tick(N + 4);

        // R3: power-good before stable
        pwr_good = 1'b0;
        tick(3);
        clk_stable = 1'b0;
        pwr_good = 1'b1;
        expect_at(10, S_RST, 0, "R3");
        tick(11);
        clk_stable = 1'b1;
        expect_at(N + 1, S_RST, 0, "R3");
        expect_at(N + 2, S_RST, 1, "R3");
        expect_at(N + 2, S_VIOL, 0, "R3");
        tick(N + 4);

        // R4: stable drop during hold, then recovery
        pwr_good = 1'b0;
        expect_at(1, S_VIOL, 0, "R1");
        tick(3);
        clk_stable = 1'b1;
        pwr_good = 1'b1;
        tick(10);
        clk_stable = 1'b0;
        expect_at(1, S_VIOL, 1, "R4");
        expect_at(1, S_RST, 0, "R4");
        tick(5);
        clk_stable = 1'b1;
        expect_at(N + 1, S_RST, 0, "R4");
        expect_at(N + 2, S_RST, 1, "R4");
        expect_at(N + 2, S_VIOL, 1, "R4");
        tick(N + 4);

        // R5: stable lost for good, window cap forces release
        pwr_good = 1'b0;
        expect_at(1, S_VIOL, 0, "R1");
        tick(3);
        clk_stable = 1'b1;
        pwr_good = 1'b1;
        tick(10);
        clk_stable = 1'b0;
        expect_at(XMS * C - 9, S_RST, 0, "R5");
        expect_at(XMS * C - 8, S_RST, 1, "R5");
        expect_at(XMS * C - 8, S_VIOL, 1, "R5");
        tick(XMS * C - 5);

        // R1: loss clears flag and configuration
        pwr_good = 1'b0;
        expect_at(1, S_VIOL, 0, "R1");
        expect_at(1, S_CFG, 0, "R1");
        expect_at(1, S_RST, 0, "R1");
        tick(4);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule